// File: doc/BRIEF.md
# Clock Bank Divider and Output-Enable Controller

This block is the digital output stage of a multi-bank zero-delay clock buffer. A fast clock `clk` runs at twice the internal oscillator rate. A free-running phase counter derives the undivided internal clock and its divided copies from it. The block drives four banks of two outputs each:

- Banks 1 and 2 always carry the undivided clock.
- Bank 3 can divide by 2 or by 4.
- Bank 4 can divide by 2 or run as the complement of the undivided clock.

Each bank output is a single register, copied onto the bank's pins.

Several controls act on the outputs:

- An active-low synchronous enable parks every bank except bank 2 at its rest level. Bank 2 keeps running so that the external loop can stay locked on it.
- A three-level test select can route the reference clock straight to every output.
- In one test setting, the per-bank select codes act as individual bank disables.
- The edge-polarity select decides whether the reference is passed true or complemented. It also sets the rest level of an inverted bank 4.

Stops and restarts take effect only when a bank's output already sits at its rest level, so no shortened pulse is produced. Divider changes wait for the counter's terminal count.

Top module: `zdb_bank_out`

## Requirements
- R1: Banks 1 and 2 toggle on every `clk` cycle when running, so their output period is 2 cycles.
- R2: Each select pin is a 2-bit three-level code: 00 LOW, 01 MID, 10 HIGH, and 11 read as MID. Bank b's select sits in `f_sel[4(b-1)+3 : 4(b-1)]`, two pins of 2 bits each. Bank 3 has a half-period of 2 cycles for code LOW-LOW (0000), 4 cycles for HIGH-HIGH (1010), and 1 cycle for any other code.
- R3: Bank 4 has a half-period of 2 cycles for LOW-LOW and 1 cycle for other codes except HIGH-HIGH. For HIGH-HIGH it is the exact complement of bank 1.
- R4: With `test_sel` LOW and `soe_n` high, banks 1, 3 and 4 are held LOW, while bank 2 keeps toggling.
- R5: A stopped bank 4 in inverted mode rests HIGH when `pol_sel` is 1 and LOW when `pol_sel` is 0.
- R6: Bypass applies when `test_sel` is HIGH, or when it is MID with `soe_n` low. In bypass, each output equals the `ref_clk` value sampled one clock earlier, complemented when `pol_sel` is 0.
- R7: With `test_sel` MID and `soe_n` high, the internal clock is used. Every bank whose select is LOW-LOW is held LOW, and the other banks run.
- R8: A bank starts or stops only when its output is at its rest level. Every high pulse of a divide-by-4 bank lasts exactly 4 cycles, even across stop and restart.
- R9: Every rising edge of bank 3 or bank 4 coincides with a rising edge of bank 1.
- R10: A new bank 3 or bank 4 select takes effect only at the counter's terminal count, once every 8 cycles. While the divider is reconfigured, a bank moving between divide-by-2 and divide-by-4 shows only runs of 2 or 4 cycles.
- R11: During reset and on the first cycle after it, all outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the internal oscillator rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Reference clock, sampled as a level |
| test_sel | input | 2 | Three-level test select |
| soe_n | input | 1 | Active-low synchronous output enable |
| pol_sel | input | 1 | Edge polarity: 1 rising, 0 falling |
| f_sel | input | 16 | Four 4-bit bank select codes, bank 1 in the low bits |
| q_b1 | output | OUTS_PER_BANK | Bank 1 outputs |
| q_b2 | output | OUTS_PER_BANK | Bank 2 outputs |
| q_b3 | output | OUTS_PER_BANK | Bank 3 outputs |
| q_b4 | output | OUTS_PER_BANK | Bank 4 outputs |

## Verification
The bypass result appears one clock after `ref_clk` is sampled. The bench therefore compares each output with the reference value that was on the wire through the preceding edge. A divider change is due within 8 cycles, at the next terminal count. A stop, restart or disable is due within one output period, which is at most 8 cycles. For these cases the bench lets 24 cycles pass after each stimulus and then judges a 32-sample window, a multiple of every output period, by counting transitions and high samples rather than by fixing a phase. Reconfiguration and stop windows are instead checked by the length of every completed pulse, which does not depend on the exact cycle a change lands on.

// File: rtl/zdb_out_pkg.sv
package zdb_out_pkg;

  localparam int NUM_BANKS    = 4;
  localparam int SEL_W        = 4;
  localparam int DIV_LOG2_MAX = 2;
  localparam int CNT_W        = DIV_LOG2_MAX + 1;
  localparam int FB_BANK      = 1;

  typedef enum logic [1:0] {
    BM_DIV1 = 2'd0,
    BM_DIV2 = 2'd1,
    BM_DIV4 = 2'd2,
    BM_INV  = 2'd3
  } bank_mode_e;

  function automatic logic tri_low(input logic [1:0] c);
    return c == 2'b00;
  endfunction

  function automatic logic tri_high(input logic [1:0] c);
    return c == 2'b10;
  endfunction

  function automatic logic tri_mid(input logic [1:0] c);
    return c[0];
  endfunction

  function automatic logic code_ll(input logic [SEL_W-1:0] s);
    return tri_low(s[1:0]) && tri_low(s[3:2]);
  endfunction

  function automatic logic code_hh(input logic [SEL_W-1:0] s);
    return tri_high(s[1:0]) && tri_high(s[3:2]);
  endfunction

  function automatic bank_mode_e bank3_decode(input logic [SEL_W-1:0] s);
    if (code_ll(s)) return BM_DIV2;
    if (code_hh(s)) return BM_DIV4;
    return BM_DIV1;
  endfunction

  function automatic bank_mode_e bank4_decode(input logic [SEL_W-1:0] s);
    if (code_ll(s)) return BM_DIV2;
    if (code_hh(s)) return BM_INV;
    return BM_DIV1;
  endfunction

  // Non-inverted levels are all low at the terminal count and all rise together after it.
  function automatic logic bank_level(input bank_mode_e m, input logic [CNT_W-1:0] c);
    case (m)
      BM_DIV2: return ~c[1];
      BM_DIV4: return ~c[DIV_LOG2_MAX];
      BM_INV:  return c[0];
      default: return ~c[0];
    endcase
  endfunction

endpackage

// File: rtl/zdb_phase_ctr.sv
module zdb_phase_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tc = &cnt;

endmodule

// File: rtl/zdb_bank_gate.sv
module zdb_bank_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic park,
  input  logic want,
  input  logic byp,
  input  logic ref_lvl,
  output logic run,
  output logic q
);

  logic run_nxt;

  // The run flag may only change while the natural level equals the rest level.
  assign run_nxt = (lvl == park) ? want : run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      q   <= 1'b0;
    end else begin
      run <= run_nxt;
      q   <= byp ? ref_lvl : (run_nxt ? lvl : park);
    end
  end

endmodule

// File: rtl/zdb_bank_out.sv
module zdb_bank_out
  import zdb_out_pkg::*;
#(
  parameter int OUTS_PER_BANK = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_clk,
  input  logic [1:0]                   test_sel,
  input  logic                         soe_n,
  input  logic                         pol_sel,
  input  logic [NUM_BANKS*SEL_W-1:0]   f_sel,
  output logic [OUTS_PER_BANK-1:0]     q_b1,
  output logic [OUTS_PER_BANK-1:0]     q_b2,
  output logic [OUTS_PER_BANK-1:0]     q_b3,
  output logic [OUTS_PER_BANK-1:0]     q_b4
);

  logic [CNT_W-1:0]     cnt;
  logic                 tc;
  bank_mode_e           div3_mode, div4_mode;
  bank_mode_e           mode_vec [NUM_BANKS];
  logic                 byp, dis_mode, ref_lvl;
  logic [NUM_BANKS-1:0] lvl_vec, park_vec, want_vec, run_vec, bank_q;

  zdb_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .tc    (tc)
  );

  // Select codes are captured only at the terminal count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div3_mode <= BM_DIV1;
      div4_mode <= BM_DIV1;
    end else if (tc) begin
      div3_mode <= bank3_decode(f_sel[2*SEL_W +: SEL_W]);
      div4_mode <= bank4_decode(f_sel[3*SEL_W +: SEL_W]);
    end
  end

  always_comb begin
    mode_vec[0] = BM_DIV1;
    mode_vec[1] = BM_DIV1;
    mode_vec[2] = div3_mode;
    mode_vec[3] = div4_mode;
  end

  assign byp      = tri_high(test_sel) || (tri_mid(test_sel) && !soe_n);
  assign dis_mode = tri_mid(test_sel) && soe_n;
  assign ref_lvl  = ref_clk ~^ pol_sel;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign lvl_vec[b]  = bank_level(mode_vec[b], cnt);
    assign park_vec[b] = (mode_vec[b] == BM_INV) ? pol_sel : 1'b0;
    if (b == FB_BANK) begin : g_fb
      assign want_vec[b] = dis_mode ? !code_ll(f_sel[b*SEL_W +: SEL_W]) : 1'b1;
    end else begin : g_std
      assign want_vec[b] = dis_mode ? !code_ll(f_sel[b*SEL_W +: SEL_W]) : !soe_n;
    end
    zdb_bank_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl_vec[b]),
      .park    (park_vec[b]),
      .want    (want_vec[b]),
      .byp     (byp),
      .ref_lvl (ref_lvl),
      .run     (run_vec[b]),
      .q       (bank_q[b])
    );
  end

  assign q_b1 = {OUTS_PER_BANK{bank_q[0]}};
  assign q_b2 = {OUTS_PER_BANK{bank_q[1]}};
  assign q_b3 = {OUTS_PER_BANK{bank_q[2]}};
  assign q_b4 = {OUTS_PER_BANK{bank_q[3]}};

endmodule

// File: rtl/zdb_bank_out_chk.sv
module zdb_bank_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_clk,
  input logic [1:0] test_sel,
  input logic       soe_n,
  input logic       pol_sel,
  input logic [3:0] bank_q,
  input logic [3:0] run_vec,
  input logic [3:0] park_vec,
  input logic       tc,
  input logic [1:0] div3_mode,
  input logic [1:0] div4_mode
);

  logic c_byp, c_nrm;
  assign c_byp = (test_sel == 2'b10) || ((test_sel == 2'b01 || test_sel == 2'b11) && !soe_n);
  assign c_nrm = (test_sel == 2'b00);

  for (genvar i = 0; i < 4; i++) begin : g_chk
    // R8: a start or stop lands on the rest level
    assert_stop_at_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((run_vec[i] != $past(run_vec[i])) && !$past(c_byp)) |-> bank_q[i] == $past(park_vec[i]));
    // R6: bypass copies the reference one cycle later
    assert_bypass_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(c_byp) |-> bank_q[i] == ($past(ref_clk) ~^ $past(pol_sel)));
  end

  assert_div3_at_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div3_mode != $past(div3_mode)) |-> $past(tc));

  assert_div4_at_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (div4_mode != $past(div4_mode)) |-> $past(tc));

  assert_fb_bank_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(c_nrm) && $past(c_nrm, 2) && $past(run_vec[1], 2))
      |-> (run_vec[1] && bank_q[1] != $past(bank_q[1])));

  assert_bank1_stopped_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(c_byp) && !run_vec[0]) |-> !bank_q[0]);

endmodule

bind zdb_bank_out zdb_bank_out_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_clk   (ref_clk),
  .test_sel  (test_sel),
  .soe_n     (soe_n),
  .pol_sel   (pol_sel),
  .bank_q    ({q_b4[0], q_b3[0], q_b2[0], q_b1[0]}),
  .run_vec   (run_vec),
  .park_vec  (park_vec),
  .tc        (tc),
  .div3_mode (div3_mode),
  .div4_mode (div4_mode)
);

// File: tb/test_zdb_bank_out.sv
module test_zdb_bank_out;

  localparam int OPB = 2;
  localparam logic [1:0] T_LOW = 2'b00, T_MID = 2'b01, T_HIGH = 2'b10, T_MID2 = 2'b11;
  localparam logic [3:0] C_LL = 4'b0000, C_HH = 4'b1010, C_MM = 4'b0101;
  localparam logic [2:0] K_LOW = 3'd0, K_HIGH = 3'd1, K_H1 = 3'd2, K_H2 = 3'd3,
                         K_H4 = 3'd4, K_INV = 3'd5, K_REF = 3'd6;

  // {test, soe_n, pol, f_sel{b4,b3,b2,b1}, expect{b4,b3,b2,b1}}
  localparam logic [31:0] VEC [12] = '{
    {T_LOW,  1'b0, 1'b1, C_MM, C_MM, C_MM, C_MM, K_H1,  K_H1,  K_H1,  K_H1},
    {T_LOW,  1'b0, 1'b1, C_LL, C_LL, C_MM, C_MM, K_H2,  K_H2,  K_H1,  K_H1},
    {T_LOW,  1'b0, 1'b1, C_HH, C_HH, C_MM, C_MM, K_INV, K_H4,  K_H1,  K_H1},
    {T_LOW,  1'b1, 1'b1, C_HH, C_HH, C_MM, C_MM, K_HIGH, K_LOW, K_H1, K_LOW},
    {T_LOW,  1'b1, 1'b0, C_HH, C_HH, C_MM, C_MM, K_LOW, K_LOW, K_H1,  K_LOW},
    {T_LOW,  1'b1, 1'b1, C_MM, C_LL, C_MM, C_MM, K_LOW, K_LOW, K_H1,  K_LOW},
    {T_HIGH, 1'b0, 1'b1, C_MM, C_MM, C_MM, C_MM, K_REF, K_REF, K_REF, K_REF},
    {T_HIGH, 1'b1, 1'b0, C_MM, C_MM, C_MM, C_MM, K_REF, K_REF, K_REF, K_REF},
    {T_MID,  1'b0, 1'b1, C_LL, C_LL, C_LL, C_LL, K_REF, K_REF, K_REF, K_REF},
    {T_MID,  1'b1, 1'b1, C_LL, C_HH, C_MM, C_LL, K_LOW, K_H4,  K_H1,  K_LOW},
    {T_MID2, 1'b1, 1'b1, C_HH, C_LL, C_LL, C_MM, K_INV, K_LOW, K_LOW, K_H1},
    {T_MID2, 1'b1, 1'b0, C_MM, C_MM, C_MM, C_MM, K_H1,  K_H1,  K_H1,  K_H1}
  };

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, soe_n = 1'b0, pol_sel = 1'b1;
  logic [1:0]  test_sel = T_LOW;
  logic [15:0] f_sel = {C_MM, C_MM, C_MM, C_MM};
  logic [OPB-1:0] q_b1, q_b2, q_b3, q_b4;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  zdb_bank_out #(.OUTS_PER_BANK(OPB)) i_zdb_bank_out (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .test_sel(test_sel), .soe_n(soe_n),
    .pol_sel(pol_sel), .f_sel(f_sel), .q_b1(q_b1), .q_b2(q_b2), .q_b3(q_b3), .q_b4(q_b4)
  );

  function automatic logic [3:0] sample();
    return {q_b4[0], q_b3[0], q_b2[0], q_b1[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] t, input logic s, input logic p, input logic [15:0] f);
    @(negedge clk);
    test_sel = t; soe_n = s; pol_sel = p; f_sel = f;
  endtask

  task automatic run_vector(input logic [31:0] v, input int idx);
    int trans[4], highs[4], refbad[4], invbad;
    logic [3:0] prev, cur;
    string req;
    apply(v[31:30], v[29], v[28], v[27:12]);
    repeat (24) @(negedge clk);
    invbad = 0; prev = '0;
    for (int b = 0; b < 4; b++) begin trans[b] = 0; highs[b] = 0; refbad[b] = 0; end
    for (int i = 0; i <= 32; i++) begin
      if (i > 0) @(negedge clk);
      cur = sample();
      for (int b = 0; b < 4; b++) begin
        if (i > 0) begin
          if (cur[b] != prev[b]) trans[b]++;
          if (cur[b]) highs[b]++;
        end
        if (cur[b] != (ref_clk ~^ pol_sel)) refbad[b]++;
      end
      if (cur[3] != ~cur[0]) invbad++;
      prev = cur;
      if (i % 3 == 2) ref_clk = ~ref_clk;
    end
    for (int b = 0; b < 4; b++) begin
      logic [2:0] k;
      bit ok;
      k = v[3*b +: 3];
      if (k == K_REF) req = "R6";
      else if (test_sel[0] && soe_n) req = "R7";
      else if (soe_n && k == K_HIGH) req = "R5";
      else if (soe_n && k == K_LOW) req = "R4";
      else if (b < 2) req = "R1";
      else if (b == 2) req = "R2";
      else req = "R3";
      case (k)
        K_LOW:  ok = (trans[b] == 0) && (highs[b] == 0);
        K_HIGH: ok = (highs[b] == 32);
        K_H1:   ok = (trans[b] == 32) && (highs[b] == 16);
        K_H2:   ok = (trans[b] == 16) && (highs[b] == 16);
        K_H4:   ok = (trans[b] == 8) && (highs[b] == 16);
        K_INV:  ok = (trans[b] == 32) && (invbad == 0);
        default: ok = (refbad[b] == 0);
      endcase
      check(ok, req,
            $sformatf("vec%0d bank%0d trans=%0d highs=%0d refbad=%0d invbad=%0d",
                      idx, b + 1, trans[b], highs[b], refbad[b], invbad),
            $sformatf("kind %0d", k));
    end
  endtask

  task automatic watch_runs(input int ncyc, input int bank, input logic [15:0] hmask,
                            input logic [15:0] lmask, output int bad);
    logic prev, cur;
    int len;
    bit started;
    logic [3:0] s;
    bad = 0; len = 1; started = 0;
    s = sample(); prev = s[bank];
    repeat (ncyc) begin
      @(negedge clk);
      s = sample(); cur = s[bank];
      if (cur == prev) begin
        if (len < 15) len++;
      end else begin
        if (started && (prev ? !hmask[len] : !lmask[len])) bad++;
        started = 1; len = 1;
      end
      prev = cur;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad3, bad1, rise_err;
    logic [3:0] pv, cv;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(sample() == 4'b0, "R11", $sformatf("%b", sample()), "0000");
    rst_n = 1'b1;
    @(negedge clk);
    check(sample() == 4'b0, "R11", $sformatf("%b", sample()), "0000 first cycle");

    for (int v = 0; v < 12; v++) run_vector(VEC[v], v);

    // R9: divided rising edges line up with bank 1
    apply(T_LOW, 1'b0, 1'b1, {C_LL, C_HH, C_MM, C_MM});
    repeat (24) @(negedge clk);
    rise_err = 0; pv = sample();
    repeat (64) begin
      @(negedge clk);
      cv = sample();
      if (((cv[2] && !pv[2]) || (cv[3] && !pv[3])) && !(cv[0] && !pv[0])) rise_err++;
      pv = cv;
    end
    check(rise_err == 0, "R9", $sformatf("%0d misaligned", rise_err), "0 misaligned");

    // R8: stop and restart a divide-by-4 bank without short pulses
    apply(T_LOW, 1'b0, 1'b1, {C_HH, C_HH, C_MM, C_MM});
    repeat (24) @(negedge clk);
    fork
      watch_runs(90, 2, 16'h0010, 16'hFFF0, bad3);
      watch_runs(90, 0, 16'h0002, 16'hFFFE, bad1);
      begin
        repeat (5) @(negedge clk);  soe_n = 1'b1;
        repeat (23) @(negedge clk); soe_n = 1'b0;
        repeat (17) @(negedge clk); soe_n = 1'b1;
        repeat (13) @(negedge clk); soe_n = 1'b0;
      end
    join
    check(bad3 == 0, "R8", $sformatf("bank3 %0d bad pulses", bad3), "0");
    check(bad1 == 0, "R8", $sformatf("bank1 %0d bad pulses", bad1), "0");

    // R10: divider changes at every phase keep runs at 2 or 4 cycles
    for (int ph = 0; ph < 8; ph++) begin
      apply(T_LOW, 1'b0, 1'b1, {C_MM, C_HH, C_MM, C_MM});
      repeat (24 + ph) @(negedge clk);
      fork
        watch_runs(48, 2, 16'h0014, 16'h0014, bad3);
        begin @(negedge clk); f_sel = {C_MM, C_LL, C_MM, C_MM}; end
      join
      check(bad3 == 0, "R10", $sformatf("div4->div2 phase %0d bad=%0d", ph, bad3), "0");
      repeat (ph) @(negedge clk);
      fork
        watch_runs(48, 2, 16'h0014, 16'h0014, bad3);
        begin @(negedge clk); f_sel = {C_MM, C_HH, C_MM, C_MM}; end
      join
      check(bad3 == 0, "R10", $sformatf("div2->div4 phase %0d bad=%0d", ph, bad3), "0");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule